// File: doc/BRIEF.md
# Bidirectional GPIO Port with Peripheral Takeover

This block is an eight-pin general-purpose I/O port attached to a simple processor register bus. Software programs a direction mask and an output data latch, and reads back either the latch or the actual level seen on the pads. Each pin can also be claimed by an on-chip peripheral. A claiming peripheral may force the pin to drive, or force it to stay high-impedance, and it supplies the value the pin drives.

The stored direction register is never touched by a takeover. Software can therefore run read-modify-write sequences on the direction mask or the latch while peripherals own some pins, and no forced state leaks into the registers. Pad inputs are treated as asynchronous. They pass through a synchronizer before they reach the bus read path or the peripherals' receive inputs.

The register bus is a plain control interface and has no back-pressure. A write completes in the cycle it is presented. A read returns data combinationally from the address in that same cycle.

Top module: `gpio_port_ovr`

## Requirements
- R1: While reset is active and right after it, every direction bit is 1 (all pins are inputs), the output latch is 0, and no pad output enable is asserted.
- R2: With no peripheral claim on a pin, a direction bit of 1 deasserts that pad's output enable. A direction bit of 0 asserts it, and the pad then drives the latch bit.
- R3: A read at address 1 returns the stored latch value, whatever level is present on the pads.
- R4: A read at address 0, and the peripheral receive bus, show the pad level that was sampled two clock edges earlier.
- R5: A write at address 0 or address 1 loads the output latch on the next clock edge. A write at address 2 loads the direction register.
- R6: When a pin's peripheral select and force-output flag are both 1, the pad output enable is 1 regardless of the direction bit. This holds even if the force-input flag is also 1.
- R7: When a pin's select and force-input flag are 1 and force-output is 0, the pad output enable is 0 regardless of the direction bit.
- R8: Force flags on a pin whose select is 0 have no effect. The direction bit alone decides that pin's output enable.
- R9: A pin whose select is 1 drives the peripheral's data bit instead of the latch bit.
- R10: A read at address 2 returns the software-written direction value while overrides are active.
- R11: Address 3 reads as all zeros, and a write to it changes neither the latch nor the direction register.
- R12: While the write enable is 0, the latch and the direction register hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 pins, 1 latch, 2 direction, 3 unused) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| pad_in | input | 8 | Raw pad input levels (asynchronous) |
| pad_out | output | 8 | Value each pad drives |
| pad_oe | output | 8 | Per-pad output enable (1 = drive) |
| prf_sel | input | 8 | Per-pin peripheral claim |
| prf_force_out | input | 8 | Per-pin force-drive request |
| prf_force_in | input | 8 | Per-pin force-high-impedance request |
| prf_dout | input | 8 | Peripheral data to drive |
| prf_din | output | 8 | Synchronized pad levels for peripherals |

## Verification
The assertions assume three things about the inputs. Pad inputs may change at any cycle boundary. Force flags are only meaningful when combined with a select bit. The bus write strobe, address and data are stable across each sampling edge. The stimulus changes every input only at the falling clock edge, so no input moves near a rising edge. It mixes directed passes with random cycles. The random cycles include pins with force flags but no select, pins with both flags set, and writes to the unused address. The synchronizer assertion waits for two edges after reset, so the pre-reset pad history never counts against it.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  typedef enum logic [1:0] {
    REG_PIN  = 2'd0,
    REG_LAT  = 2'd1,
    REG_DIR  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_ovr_sync.sv
module gpio_ovr_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_in,
  output logic [W-1:0] sync_out
);
  localparam int LAST = STAGES - 1;

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= raw_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign sync_out = chain[LAST];
endmodule

// File: rtl/gpio_ovr_regs.sv
module gpio_ovr_regs
  import gpio_ovr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] rdata,
  output logic [W-1:0] lat_q,
  output logic [W-1:0] dir_q
);
  reg_sel_e sel;
  logic     lat_we;
  logic     dir_we;

  assign sel    = reg_sel_e'(addr);
  assign lat_we = wr_en && (sel == REG_PIN || sel == REG_LAT);
  assign dir_we = wr_en && (sel == REG_DIR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= '0;
    else if (lat_we) lat_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '1;
    else if (dir_we) dir_q <= wdata;
  end

  always_comb begin
    unique case (sel)
      REG_PIN: rdata = pin_sync;
      REG_LAT: rdata = lat_q;
      REG_DIR: rdata = dir_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_ovr_pinmux.sv
module gpio_ovr_pinmux #(
  parameter int W = 8
) (
  input  logic [W-1:0] lat_q,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] sel,
  input  logic [W-1:0] force_out,
  input  logic [W-1:0] force_in,
  input  logic [W-1:0] prf_data,
  output logic [W-1:0] out_val,
  output logic [W-1:0] out_en
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic take_out;
    logic take_in;
    assign take_out = sel[i] & force_out[i];
    assign take_in  = sel[i] & force_in[i] & ~force_out[i];
    always_comb begin
      if (take_out)     out_en[i] = 1'b1;
      else if (take_in) out_en[i] = 1'b0;
      else              out_en[i] = ~dir_q[i];
    end
    assign out_val[i] = sel[i] ? prf_data[i] : lat_q[i];
  end
endmodule

// File: rtl/gpio_port_ovr.sv
module gpio_port_ovr #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_wr,
  input  logic [1:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  input  logic [W-1:0] prf_sel,
  input  logic [W-1:0] prf_force_out,
  input  logic [W-1:0] prf_force_in,
  input  logic [W-1:0] prf_dout,
  output logic [W-1:0] prf_din
);
  logic [W-1:0] pin_sync;
  logic [W-1:0] lat_q;
  logic [W-1:0] dir_q;

  gpio_ovr_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_in   (pad_in),
    .sync_out (pin_sync)
  );

  gpio_ovr_regs #(.W(W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .pin_sync (pin_sync),
    .rdata    (bus_rdata),
    .lat_q    (lat_q),
    .dir_q    (dir_q)
  );

  gpio_ovr_pinmux #(.W(W)) u_mux (
    .lat_q     (lat_q),
    .dir_q     (dir_q),
    .sel       (prf_sel),
    .force_out (prf_force_out),
    .force_in  (prf_force_in),
    .prf_data  (prf_dout),
    .out_val   (pad_out),
    .out_en    (pad_oe)
  );

  assign prf_din = pin_sync;
endmodule

// File: rtl/gpio_port_ovr_chk.sv
module gpio_port_ovr_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_wr,
  input logic [1:0]   bus_addr,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] bus_rdata,
  input logic [W-1:0] pad_in,
  input logic [W-1:0] pad_out,
  input logic [W-1:0] pad_oe,
  input logic [W-1:0] prf_sel,
  input logic [W-1:0] prf_force_out,
  input logic [W-1:0] prf_force_in,
  input logic [W-1:0] prf_dout,
  input logic [W-1:0] prf_din,
  input logic [W-1:0] lat_q,
  input logic [W-1:0] dir_q
);
  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_rst <= '0;
    else if (since_rst != 3)  since_rst <= since_rst + 2'd1;
  end

  p_latch_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr[1]) |=> (lat_q == $past(bus_wdata)));

  p_dir_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd2) |=> (dir_q == $past(bus_wdata)));

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ($stable(lat_q) && $stable(dir_q)));

  p_unused_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd3) |=> ($stable(lat_q) && $stable(dir_q)));

  p_sync_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    since_rst[1] |-> (prf_din == $past(pad_in, 2)));

  p_force_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((prf_sel & prf_force_out & ~pad_oe) == '0));

  p_force_in_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((prf_sel & prf_force_in & ~prf_force_out & pad_oe) == '0));

  p_prf_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((prf_sel & (pad_out ^ prf_dout)) == '0));

  p_latch_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd1) |-> (bus_rdata == lat_q));
endmodule

bind gpio_port_ovr gpio_port_ovr_chk #(.W(W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_wr        (bus_wr),
  .bus_addr      (bus_addr),
  .bus_wdata     (bus_wdata),
  .bus_rdata     (bus_rdata),
  .pad_in        (pad_in),
  .pad_out       (pad_out),
  .pad_oe        (pad_oe),
  .prf_sel       (prf_sel),
  .prf_force_out (prf_force_out),
  .prf_force_in  (prf_force_in),
  .prf_dout      (prf_dout),
  .prf_din       (prf_din),
  .lat_q         (lat_q),
  .dir_q         (dir_q)
);

// File: tb/sim_gpio_port_ovr.sv
`timescale 1ns/1ps
module sim_gpio_port_ovr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_out;
  logic [7:0] pad_oe;
  logic [7:0] prf_sel = '0;
  logic [7:0] prf_force_out = '0;
  logic [7:0] prf_force_in = '0;
  logic [7:0] prf_dout = '0;
  logic [7:0] prf_din;

  int tests = 0;
  int fails = 0;

  logic [7:0] m_lat;
  logic [7:0] m_dir;
  logic [7:0] pin_hist[$];

  always #2.5 clk = ~clk;

  gpio_port_ovr u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .prf_sel(prf_sel),
    .prf_force_out(prf_force_out), .prf_force_in(prf_force_in),
    .prf_dout(prf_dout), .prf_din(prf_din)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_oe();
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      if (prf_sel[i] && prf_force_out[i])     r[i] = 1'b1;  // R6
      else if (prf_sel[i] && prf_force_in[i]) r[i] = 1'b0;  // R7
      else                                    r[i] = !m_dir[i]; // R2, R8
    end
    return r;
  endfunction

  function automatic logic [7:0] exp_out();
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = prf_sel[i] ? prf_dout[i] : m_lat[i]; // R9
    return r;
  endfunction

  function automatic logic [7:0] exp_rd();
    case (bus_addr)
      2'd0:    return pin_hist[pin_hist.size()-2]; // R4
      2'd1:    return m_lat;                       // R3
      2'd2:    return m_dir;                       // R10
      default: return 8'h00;                       // R11
    endcase
  endfunction

  // one cycle: drive at falling edge, compare, then update the model at the rising edge
  task automatic step(input logic wr, input logic [1:0] a, input logic [7:0] wd,
                      input logic [7:0] pin, input logic [7:0] sel,
                      input logic [7:0] fo, input logic [7:0] fi, input logic [7:0] dout);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = wd; pad_in = pin;
    prf_sel = sel; prf_force_out = fo; prf_force_in = fi; prf_dout = dout;
    #1;
    check("R2/R6/R7/R8 pad_oe", pad_oe, exp_oe());
    check("R2/R9 pad_out", pad_out, exp_out());
    check(a == 2'd0 ? "R4 pin read" : a == 2'd1 ? "R3 latch read" :
          a == 2'd2 ? "R10 dir read" : "R11 unused read", bus_rdata, exp_rd());
    check("R4 prf_din", prf_din, pin_hist[pin_hist.size()-2]);
    @(posedge clk);
    if (wr) begin
      if (a == 2'd0 || a == 2'd1) m_lat = wd;  // R5
      else if (a == 2'd2)         m_dir = wd;  // R5; address 3 ignored (R11)
    end                                         // no write: hold (R12)
    pin_hist.push_back(pin);
    if (pin_hist.size() > 4) void'(pin_hist.pop_front());
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    m_lat = '0; m_dir = '1;
    pin_hist.push_back(8'h00); pin_hist.push_back(8'h00);
    pad_in = 8'h5A;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1 pad_oe in reset", pad_oe, 8'h00);
    bus_addr = 2'd2; #0.5;
    check("R1 dir in reset", bus_rdata, 8'hFF);
    bus_addr = 2'd1; #0.5;
    check("R1 latch in reset", bus_rdata, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk);
    pin_hist.push_back(8'h5A);

    step(0, 2'd2, 8'h00, 8'h5A, 8'h00, 8'h00, 8'h00, 8'h00);       // R1 dir after reset
    step(1, 2'd1, 8'hC3, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);       // R5 latch via addr 1
    step(1, 2'd2, 8'h0F, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00);       // R5 dir write
    step(0, 2'd1, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00);       // R2, R3 latch vs pins
    step(1, 2'd0, 8'h3C, 8'hA5, 8'h00, 8'h00, 8'h00, 8'h00);       // R5 latch via addr 0
    step(0, 2'd0, 8'h00, 8'hA5, 8'h00, 8'h00, 8'h00, 8'h00);       // R4
    step(0, 2'd0, 8'h00, 8'hA5, 8'h00, 8'h00, 8'h00, 8'h00);       // R4 two edges later
    step(0, 2'd2, 8'h00, 8'h00, 8'hF0, 8'hF0, 8'h00, 8'hAA);       // R6, R9, R10
    step(0, 2'd2, 8'h00, 8'h00, 8'h0F, 8'h00, 8'h0F, 8'h55);       // R7, R10
    step(0, 2'd1, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'h96);       // R6 priority
    step(0, 2'd1, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'hFF);       // R8 ignored flags
    step(1, 2'd3, 8'hEE, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);       // R11 write ignored
    step(0, 2'd1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);       // R11 latch unchanged
    step(0, 2'd2, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);       // R11 dir unchanged
    step(0, 2'd0, 8'h77, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);       // R12 no write
    step(0, 2'd1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);       // R12 latch held
    for (int n = 0; n < 400; n++) begin
      step($urandom_range(0, 1), 2'($urandom_range(0, 3)), 8'($urandom),
           8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule